// File: doc/BRIEF.md
# Three-Multiplier Complex Rotator

This block multiplies a stream of complex fixed-point samples by a complex coefficient, normally a unit-magnitude phasor (cosine on one input, sine on the other). In a frequency-domain pulse-compression chain it sits between the forward and inverse transforms and applies the matched-filter spectrum bin by bin. One sample and coefficient pair may enter on every clock, and each pair is qualified by a valid flag. The product leaves after a fixed latency of three clocks, carrying its own valid flag.

The direct form needs four real multipliers. This block needs three. The sample sum is multiplied by the cosine, and that product is shared by both output lanes. Each of the two remaining products multiplies one sample component by a sum or difference of the two coefficient parts. The arithmetic has three register stages: pre-add, multiply and post-add with rounding. The full-precision result is rounded back to the sample width. By default it is clamped to a range that is symmetric about zero. A parameter selects two's-complement wrap instead. A coefficient of non-unit magnitude gives the ordinary complex product, because the algebra is the same.

Top module: `cplx_rot3`

## Requirements
- R1: With sample a + jb and coefficient c + js, and F = CW-1 fraction bits in the coefficient, the real output is floor((a·c − b·s + 2^(F−1)) / 2^F). The value is exact and is then limited as in R4.
- R2: Under the same rounding and limiting, the imaginary output is floor((b·c + a·s + 2^(F−1)) / 2^F).
- R3: out_vld equals in_vld delayed by exactly three clocks. A pair accepted on every clock gives a result on every clock, in the same order.
- R4: In the default saturating mode, a rounded value above 2^(DW−1)−1 comes out as 2^(DW−1)−1, and a value below −(2^(DW−1)−1) comes out as −(2^(DW−1)−1). The most negative code never appears on a valid output.
- R5: While out_vld is low, y_re and y_im keep the value of the last valid product. Inputs presented with in_vld low do not change them.
- R6: While rst_n is low, out_vld is 0 and both outputs are 0.
- R7: A valid sample with both components zero gives a zero result on both lanes, whatever the coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Sample and coefficient pair is valid this cycle |
| x_re | input | DW | Sample real part, signed |
| x_im | input | DW | Sample imaginary part, signed |
| c_cos | input | CW | Coefficient real part, signed, CW-1 fraction bits |
| c_sin | input | CW | Coefficient imaginary part, signed, CW-1 fraction bits |
| out_vld | output | 1 | Product valid |
| y_re | output | DW | Product real part, signed |
| y_im | output | DW | Product imaginary part, signed |

## Verification
Two things can fall in the same clock: the output stage clamps a product on both lanes, and a new pair enters the pipeline behind it with no gap. The bench streams full-scale samples against coefficients of magnitude one, placed between ordinary random pairs, and it also interleaves bubbles. This checks that clamping and the hold of R5 leave the neighbouring results alone. Every output cycle is compared with a four-multiplier reference that the bench computes itself, and a clamped lane is judged against the symmetric limits.

// File: rtl/cplx_rot3_pkg.sv
package cplx_rot3_pkg;
   // overflow handling of the output stage
   typedef enum logic {
      OVF_SAT  = 1'b0,   // symmetric clamp
      OVF_WRAP = 1'b1    // two's complement wrap
   } ovf_mode_e;
endpackage

// File: rtl/cplx_rot3_pre.sv
// Stage 1: the three pre-adders, with the operands carried forward.
module cplx_rot3_pre #(
   parameter int DW = 16,
   parameter int CW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 vld_i,
   input  logic signed [DW-1:0] xr_i,
   input  logic signed [DW-1:0] xi_i,
   input  logic signed [CW-1:0] cr_i,
   input  logic signed [CW-1:0] ci_i,
   output logic                 vld_o,
   output logic signed [DW:0]   xsum_o,   // xr + xi
   output logic signed [CW:0]   csum_o,   // cos + sin
   output logic signed [CW:0]   cdif_o,   // sin - cos
   output logic signed [DW-1:0] xr_o,
   output logic signed [DW-1:0] xi_o,
   output logic signed [CW-1:0] cr_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         xsum_o <= '0;
         csum_o <= '0;
         cdif_o <= '0;
         xr_o   <= '0;
         xi_o   <= '0;
         cr_o   <= '0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            xsum_o <= (DW+1)'(xr_i) + (DW+1)'(xi_i);
            csum_o <= (CW+1)'(cr_i) + (CW+1)'(ci_i);
            cdif_o <= (CW+1)'(ci_i) - (CW+1)'(cr_i);
            xr_o   <= xr_i;
            xi_o   <= xi_i;
            cr_o   <= cr_i;
         end
      end
   end
endmodule

// File: rtl/cplx_rot3_mul.sv
// Stage 2: the three real products.
module cplx_rot3_mul #(
   parameter int DW = 16,
   parameter int CW = 16,
   localparam int PW = DW + CW + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 vld_i,
   input  logic signed [DW:0]   xsum_i,
   input  logic signed [CW:0]   csum_i,
   input  logic signed [CW:0]   cdif_i,
   input  logic signed [DW-1:0] xr_i,
   input  logic signed [DW-1:0] xi_i,
   input  logic signed [CW-1:0] cr_i,
   output logic                 vld_o,
   output logic signed [PW-1:0] k1_o,   // shared by both lanes
   output logic signed [PW-1:0] k2_o,
   output logic signed [PW-1:0] k3_o
);
   logic signed [PW-1:0] p1, p2, p3;

   always_comb begin
      p1 = PW'(cr_i) * PW'(xsum_i);
      p2 = PW'(xi_i) * PW'(csum_i);
      p3 = PW'(xr_i) * PW'(cdif_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         k1_o  <= '0;
         k2_o  <= '0;
         k3_o  <= '0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            k1_o <= p1;
            k2_o <= p2;
            k3_o <= p3;
         end
      end
   end
endmodule

// File: rtl/cplx_rot3_post.sv
// Stage 3: post-adders, rounding and the output fit.
module cplx_rot3_post
   import cplx_rot3_pkg::*;
#(
   parameter int        DW  = 16,
   parameter int        CW  = 16,
   parameter ovf_mode_e OVF = OVF_SAT,
   localparam int PW = DW + CW + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 vld_i,
   input  logic signed [PW-1:0] k1_i,
   input  logic signed [PW-1:0] k2_i,
   input  logic signed [PW-1:0] k3_i,
   output logic                 vld_o,
   output logic signed [DW-1:0] yr_o,
   output logic signed [DW-1:0] yi_o
);
   localparam int SW = PW + 1;
   localparam int FR = CW - 1;
   localparam logic signed [SW-1:0] HALF = SW'(2 ** (FR - 1));
   localparam logic signed [SW-1:0] MAXV = SW'((2 ** (DW - 1)) - 1);
   localparam logic signed [SW-1:0] MINV = -MAXV;

   logic signed [SW-1:0] sr, si, rr, ri;
   logic signed [DW-1:0] fr, fi;

   always_comb begin
      sr = SW'(k1_i) - SW'(k2_i);
      si = SW'(k1_i) + SW'(k3_i);
      rr = (sr + HALF) >>> FR;
      ri = (si + HALF) >>> FR;
   end

   if (OVF == OVF_SAT) begin : g_sat
      function automatic logic signed [DW-1:0] clamp(input logic signed [SW-1:0] v);
         if (v > MAXV)      return MAXV[DW-1:0];
         else if (v < MINV) return MINV[DW-1:0];
         else               return v[DW-1:0];
      endfunction
      always_comb begin
         fr = clamp(rr);
         fi = clamp(ri);
      end
   end else begin : g_wrap
      always_comb begin
         fr = rr[DW-1:0];
         fi = ri[DW-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         yr_o  <= '0;
         yi_o  <= '0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            yr_o <= fr;
            yi_o <= fi;
         end
      end
   end
endmodule

// File: rtl/cplx_rot3.sv
// Complex rotator with three real multipliers.
module cplx_rot3
   import cplx_rot3_pkg::*;
#(
   parameter int        DW  = 16,
   parameter int        CW  = 16,
   parameter ovf_mode_e OVF = OVF_SAT
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic [DW-1:0] x_re,
   input  logic [DW-1:0] x_im,
   input  logic [CW-1:0] c_cos,
   input  logic [CW-1:0] c_sin,
   output logic          out_vld,
   output logic [DW-1:0] y_re,
   output logic [DW-1:0] y_im
);
   localparam int PW = DW + CW + 1;

   if (DW < 4 || DW > 31) begin : g_bad_dw
      $error("cplx_rot3: DW must lie in 4..31");
   end
   if (CW < 4 || CW > 31) begin : g_bad_cw
      $error("cplx_rot3: CW must lie in 4..31");
   end

   logic                 v1, v2;
   logic signed [DW:0]   xsum;
   logic signed [CW:0]   csum, cdif;
   logic signed [DW-1:0] xr1, xi1;
   logic signed [CW-1:0] cr1;
   logic signed [PW-1:0] k1, k2, k3;
   logic signed [DW-1:0] yr, yi;

   cplx_rot3_pre #(.DW(DW), .CW(CW)) u_pre (
      .clk(clk), .rst_n(rst_n), .vld_i(in_vld),
      .xr_i($signed(x_re)), .xi_i($signed(x_im)),
      .cr_i($signed(c_cos)), .ci_i($signed(c_sin)),
      .vld_o(v1), .xsum_o(xsum), .csum_o(csum), .cdif_o(cdif),
      .xr_o(xr1), .xi_o(xi1), .cr_o(cr1)
   );

   cplx_rot3_mul #(.DW(DW), .CW(CW)) u_mul (
      .clk(clk), .rst_n(rst_n), .vld_i(v1),
      .xsum_i(xsum), .csum_i(csum), .cdif_i(cdif),
      .xr_i(xr1), .xi_i(xi1), .cr_i(cr1),
      .vld_o(v2), .k1_o(k1), .k2_o(k2), .k3_o(k3)
   );

   cplx_rot3_post #(.DW(DW), .CW(CW), .OVF(OVF)) u_post (
      .clk(clk), .rst_n(rst_n), .vld_i(v2),
      .k1_i(k1), .k2_i(k2), .k3_i(k3),
      .vld_o(out_vld), .yr_o(yr), .yi_o(yi)
   );

   assign y_re = yr;
   assign y_im = yi;
endmodule

// File: rtl/cplx_rot3_chk.sv
module cplx_rot3_chk
   import cplx_rot3_pkg::*;
#(
   parameter int        DW  = 16,
   parameter ovf_mode_e OVF = OVF_SAT
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_vld,
   input logic [DW-1:0] x_re,
   input logic [DW-1:0] x_im,
   input logic          out_vld,
   input logic [DW-1:0] y_re,
   input logic [DW-1:0] y_im
);
   localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           age <= 2'd0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   // R3
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3) |-> (out_vld == $past(in_vld, 3)));

   // R5
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_vld |-> ($stable(y_re) && $stable(y_im)));

   // R7
   zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((age == 2'd3) && $past(in_vld && x_re == '0 && x_im == '0, 3))
      |-> (y_re == '0 && y_im == '0));

   if (OVF == OVF_SAT) begin : g_sat_chk
      // R4
      sym_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_vld |-> (y_re != MOST_NEG && y_im != MOST_NEG));
   end
endmodule

bind cplx_rot3 cplx_rot3_chk #(.DW(DW), .OVF(OVF)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .x_re(x_re), .x_im(x_im),
   .out_vld(out_vld), .y_re(y_re), .y_im(y_im)
);

// File: tb/cplx_rot3_bench.sv
module cplx_rot3_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int CW = 16;
   localparam int FR = CW - 1;
   localparam int MAXV = (2 ** (DW - 1)) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_vld = 1'b0;
   logic [DW-1:0] x_re = '0, x_im = '0;
   logic [CW-1:0] c_cos = '0, c_sin = '0;
   logic out_vld;
   logic [DW-1:0] y_re, y_im;

   always #(CLK_PERIOD / 2) clk = ~clk;

   cplx_rot3 #(.DW(DW), .CW(CW)) u_cplx_rot3 (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
      .x_re(x_re), .x_im(x_im), .c_cos(c_cos), .c_sin(c_sin),
      .out_vld(out_vld), .y_re(y_re), .y_im(y_im)
   );

   int n_cmp = 0;
   int n_bad = 0;

   // expected pipeline: slot 2 is the oldest
   bit    pv[3];
   int    pr[3];
   int    pim[3];
   string pt[3];
   int    last_r = 0, last_i = 0;

   function automatic int ref_lane(longint p);
      longint r;
      r = (p + (64'sd1 <<< (FR - 1))) >>> FR;
      if (r > MAXV) r = MAXV;
      if (r < -MAXV) r = -MAXV;
      return int'(r);
   endfunction

   task automatic step(bit v, int xr, int xi, int c, int s, string tag);
      bit ev;
      int er, ei, ar, ai;
      @(negedge clk);
      ev = pv[2];
      if (ev) begin
         last_r = pr[2];
         last_i = pim[2];
      end
      er = last_r;
      ei = last_i;
      ar = int'($signed(y_re));
      ai = int'($signed(y_im));
      n_cmp++;
      if (out_vld !== ev || ar != er || ai != ei) begin
         n_bad++;
         $display("FAIL %s: vld/re/im actual %0b/%0d/%0d expected %0b/%0d/%0d",
                  pt[2], out_vld, ar, ai, ev, er, ei);
      end
      for (int k = 2; k > 0; k--) begin
         pv[k] = pv[k-1]; pr[k] = pr[k-1]; pim[k] = pim[k-1]; pt[k] = pt[k-1];
      end
      pv[0] = v;
      pr[0] = ref_lane(longint'(xr) * c - longint'(xi) * s);
      pim[0] = ref_lane(longint'(xi) * c + longint'(xr) * s);
      pt[0] = v ? tag : "R5 hold";
      in_vld = v;
      x_re = DW'(xr);
      x_im = DW'(xi);
      c_cos = CW'(c);
      c_sin = CW'(s);
   endtask

   function automatic int rnd_s(int w);
      int u;
      u = int'($urandom % (1 << w));
      return u - (1 << (w - 1));
   endfunction

   task automatic flush();
      for (int k = 0; k < 3; k++) step(1'b0, rnd_s(DW), rnd_s(DW), rnd_s(CW), rnd_s(CW), "R5");
   endtask

   task automatic t_reset();
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         n_cmp++;
         if (out_vld !== 1'b0 || y_re !== '0 || y_im !== '0) begin
            n_bad++;
            $display("FAIL R6: vld/re/im actual %0b/%0h/%0h expected 0/0/0",
                     out_vld, y_re, y_im);
         end
      end
      rst_n = 1'b1;
   endtask

   task automatic t_directed();
      step(1'b1, 1000, 2000, 32767, 0, "R1 R2 identity");
      step(1'b1, 1000, 2000, 0, 32767, "R1 R2 quarter turn");
      step(1'b1, -1234, 567, -32768, 0, "R1 R2 half turn");
      step(1'b1, 3, -5, 16384, 16384, "R1 R2 rounding");
      step(1'b1, 1, 1, 16384, -16384, "R1 R2 half code");
      flush();
   endtask

   task automatic t_stream();
      for (int k = 0; k < 60; k++) begin
         real th;
         int c, s;
         th = 6.283185307 * real'($urandom % 1000) / 1000.0;
         c = $rtoi(32767.0 * $cos(th));
         s = $rtoi(32767.0 * $sin(th));
         if (k % 5 == 4) begin
            c = rnd_s(CW);
            s = rnd_s(CW);
         end
         step(1'b1, rnd_s(DW), rnd_s(DW), c, s, "R1 R2 R3 stream");
      end
      flush();
   endtask

   task automatic t_bubbles();
      for (int k = 0; k < 30; k++)
         step((k % 3) == 0, rnd_s(DW), rnd_s(DW), rnd_s(CW), rnd_s(CW), "R3 R5 bubbles");
      flush();
   endtask

   task automatic t_saturate();
      step(1'b1, -32768, -32768, -32768, 0, "R4 upper clamp");
      step(1'b1, 1111, -2222, 30000, 9000, "R4 neighbour");
      step(1'b1, -32768, -32768, 0, -32768, "R4 lower clamp");
      step(1'b0, 0, 0, 0, 0, "R4 gap");
      step(1'b1, 32767, 32767, -32768, -32768, "R4 both lanes");
      step(1'b1, -32768, 32767, -32768, -32768, "R4 mixed");
      flush();
   endtask

   task automatic t_zero();
      step(1'b1, 0, 0, rnd_s(CW), rnd_s(CW), "R7 zero sample");
      step(1'b1, 0, 0, -32768, -32768, "R7 zero sample full coef");
      step(1'b1, 4321, -77, 0, 0, "R7 zero coef");
      flush();
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      for (int k = 0; k < 3; k++) begin
         pv[k] = 1'b0; pr[k] = 0; pim[k] = 0; pt[k] = "R6 idle";
      end
      t_reset();
      t_directed();
      t_stream();
      t_bubbles();
      t_saturate();
      t_zero();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule